// File: doc/BRIEF.md
# Network Interface Transmit Packetizer with End-to-End Credits

This block is the sending half of the interface that joins a processing core to its router. The core pushes message words, with a flag on the final word, into an outgoing message queue. The packetizer groups each message into flits of at most three words. The first flit of every message is marked as the packet head and carries three header fields: the source route to the destination, the queue id of the next router, and the number of receive credits that the local side is handing back to the far end.

Transmission is paced by an end-to-end credit counter. The counter starts at the depth of the remote receive buffer. Each word that leaves uses up one credit. A credit value that arrives in an incoming header is added back. A flit is only formed when the counter covers every word it carries, so words wait in the queue and are never dropped. On the receive side, each word that the local core consumes frees one slot. These freed slots are counted and reported in the next outgoing head flit.

Top module: `nitx_packetizer`

## Requirements
- R1: During and after reset no flit is offered (`fl_valid`=0), the queue accepts words (`msg_ready`=1), and the credit counter holds `REMOTE_DEPTH`.
- R2: Words leave in the order they were queued, unchanged. Lane k of a flit is `fl_data[k*DATA_W +: DATA_W]`, filled from lane 0 upward. Lanes at or above the size are zero.
- R3: `fl_size` is a 2-bit count of the valid words (1..3). Every flit of a message carries 3 words except the final one, which carries the remainder (3 when the length is a multiple of 3).
- R4: `fl_eop` is 1 on the final flit of each message and 0 on all others.
- R5: The first flit of each message has `fl_head`=1 and carries `cfg_route` and `cfg_qid`. Other flits have `fl_head`=0 and all header fields at zero.
- R6: A flit is formed only when the credit counter is at least its size. Forming it subtracts the size from the counter. A flit that does not fit waits, and nothing is dropped.
- R7: A cycle with `rx_hdr_valid`=1 adds `rx_hdr_credit` to the counter, which lets a waiting flit proceed.
- R8: Each cycle with `rx_consume`=1 adds one to a return count. The return count saturates at 2^`CRED_W`-1. The next head flit carries this count in `fl_credit`, and the count then restarts from zero.
- R9: While `fl_valid`=1 and `fl_ready`=0, every flit output stays unchanged.
- R10: `msg_ready` is 0 when the queue holds `QDEPTH` words, and no word offered while it is 0 is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Core offers a message word |
| msg_ready | output | 1 | Queue can take a word |
| msg_word | input | DATA_W | Message word |
| msg_last | input | 1 | Word ends its message |
| cfg_route | input | PATH_W | Configured source route |
| cfg_qid | input | QID_W | Configured next-hop queue id |
| rx_hdr_valid | input | 1 | Credit value from a received header is present |
| rx_hdr_credit | input | CRED_W | Credits returned by the remote end |
| rx_consume | input | 1 | Local core consumed one received word |
| fl_valid | output | 1 | Flit offered to the router |
| fl_ready | input | 1 | Router takes the flit |
| fl_head | output | 1 | Flit is a packet head |
| fl_route | output | PATH_W | Header route field |
| fl_qid | output | QID_W | Header queue id field |
| fl_credit | output | CRED_W | Header returned-credit field |
| fl_size | output | 2 | Number of valid words |
| fl_eop | output | 1 | Final flit of the packet |
| fl_data | output | 3*DATA_W | Word lanes |

## Verification
The checker relies on the remote end never returning more credits than the interface has spent, so the counter stays at or below `REMOTE_DEPTH`. It also assumes that the configured route and queue id do not change while a packet is partly sent. The bench keeps to the first assumption by returning credits only after it accepts a flit, and never more than the words it accepted. It keeps to the second by changing the configuration only after every queued word has been drained.

// File: rtl/nitx_pkg.sv
`timescale 1ns/1ps
package nitx_pkg;

  localparam int FLIT_LANES = 3;

  // Word count of the next flit from the queue head: stops at the first
  // message end inside the three head lanes, otherwise a full flit when
  // three words are present; zero means the head is not ready to go.
  function automatic logic [1:0] flit_size(input logic [2:0] lane_ok,
                                           input logic [2:0] lane_last);
    if (lane_ok[0] && lane_last[0]) return 2'd1;
    if (lane_ok[1] && lane_last[1]) return 2'd2;
    if (lane_ok[2])                 return 2'd3;
    return 2'd0;
  endfunction

  // End-of-packet flag of a flit of the given size.
  function automatic logic flit_ends(input logic [1:0] size,
                                     input logic [2:0] lane_last);
    case (size)
      2'd1:    return lane_last[0];
      2'd2:    return lane_last[1];
      2'd3:    return lane_last[2];
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic lane_used(input logic [1:0] size, input int lane);
    return lane < int'(size);
  endfunction

endpackage

// File: rtl/nitx_msg_queue.sv
`timescale 1ns/1ps
module nitx_msg_queue #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  parameter int LANES  = 3,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = AW + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    push,
  input  logic [DATA_W-1:0]       push_word,
  input  logic                    push_last,
  input  logic [1:0]              pop_n,
  output logic                    full,
  output logic [CNT_W-1:0]        count,
  output logic [LANES*DATA_W-1:0] peek_word,
  output logic [LANES-1:0]        peek_last
);

  logic [DATA_W:0]  mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;

  assign full = (count == CNT_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= {push_last, push_word};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      rd_ptr <= rd_ptr + AW'(pop_n);
      count  <= count + CNT_W'(push) - CNT_W'(pop_n);
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_peek
    localparam logic [AW-1:0]    OFS = AW'(k);
    localparam logic [CNT_W-1:0] NEED = CNT_W'(k);
    logic [AW-1:0] idx;
    assign idx = rd_ptr + OFS;
    assign peek_word[k*DATA_W +: DATA_W] = mem[idx][DATA_W-1:0];
    assign peek_last[k] = mem[idx][DATA_W] && (count > NEED);
  end

endmodule

// File: rtl/nitx_credit_ctrl.sv
`timescale 1ns/1ps
module nitx_credit_ctrl #(
  parameter int REMOTE_DEPTH = 6,
  parameter int CRED_W       = 4,
  parameter int CNT_W        = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [1:0]        take_n,
  input  logic              take_head,
  input  logic              rx_valid,
  input  logic [CRED_W-1:0] rx_credit,
  input  logic              consume,
  output logic [CNT_W-1:0]  credit_cnt,
  output logic [CRED_W-1:0] ret_credit
);

  localparam int SUM_W = ((CNT_W > CRED_W) ? CNT_W : CRED_W) + 1;
  localparam logic [CRED_W-1:0] RET_MAX = '1;

  logic [SUM_W-1:0] credit_sum;

  always_comb begin
    credit_sum = SUM_W'(credit_cnt);
    if (take)     credit_sum = credit_sum - SUM_W'(take_n);
    if (rx_valid) credit_sum = credit_sum + SUM_W'(rx_credit);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      credit_cnt <= CNT_W'(REMOTE_DEPTH);
      ret_credit <= '0;
    end else begin
      credit_cnt <= CNT_W'(credit_sum);
      if (take_head)
        ret_credit <= consume ? CRED_W'(1) : '0;
      else if (consume && ret_credit != RET_MAX)
        ret_credit <= ret_credit + 1'b1;
    end
  end

endmodule

// File: rtl/nitx_packetizer.sv
`timescale 1ns/1ps
module nitx_packetizer
  import nitx_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int QDEPTH       = 8,
  parameter int REMOTE_DEPTH = 6,
  parameter int PATH_W       = 12,
  parameter int QID_W        = 3,
  parameter int CRED_W       = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         msg_valid,
  output logic                         msg_ready,
  input  logic [DATA_W-1:0]            msg_word,
  input  logic                         msg_last,
  input  logic [PATH_W-1:0]            cfg_route,
  input  logic [QID_W-1:0]             cfg_qid,
  input  logic                         rx_hdr_valid,
  input  logic [CRED_W-1:0]            rx_hdr_credit,
  input  logic                         rx_consume,
  output logic                         fl_valid,
  input  logic                         fl_ready,
  output logic                         fl_head,
  output logic [PATH_W-1:0]            fl_route,
  output logic [QID_W-1:0]             fl_qid,
  output logic [CRED_W-1:0]            fl_credit,
  output logic [1:0]                   fl_size,
  output logic                         fl_eop,
  output logic [FLIT_LANES*DATA_W-1:0] fl_data
);

  localparam int LANES  = FLIT_LANES;
  localparam int FLIT_W = LANES * DATA_W;
  localparam int QCNT_W = $clog2(QDEPTH) + 1;
  localparam int CNT_W  = $clog2(REMOTE_DEPTH + 1);

  // Named internal events, observed by the bound checker.
  logic              q_full;
  logic [QCNT_W-1:0] q_count;
  logic [FLIT_W-1:0] peek_word;
  logic [LANES-1:0]  peek_last;
  logic [LANES-1:0]  lane_ok;
  logic [1:0]        form_size;
  logic              form_eop;
  logic              form_head;
  logic              form_fire;
  logic              out_free;
  logic              credit_enough;
  logic [FLIT_W-1:0] form_data;
  logic [CNT_W-1:0]  credit_cnt;
  logic [CRED_W-1:0] ret_credit;
  logic              in_pkt;

  assign msg_ready = !q_full;

  nitx_msg_queue #(
    .DATA_W (DATA_W),
    .DEPTH  (QDEPTH),
    .LANES  (LANES)
  ) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (msg_valid && !q_full),
    .push_word (msg_word),
    .push_last (msg_last),
    .pop_n     (form_fire ? form_size : 2'd0),
    .full      (q_full),
    .count     (q_count),
    .peek_word (peek_word),
    .peek_last (peek_last)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam logic [QCNT_W-1:0] NEED = QCNT_W'(k);
    assign lane_ok[k] = q_count > NEED;
    assign form_data[k*DATA_W +: DATA_W] =
      lane_used(form_size, k) ? peek_word[k*DATA_W +: DATA_W] : '0;
  end

  assign form_size     = flit_size(lane_ok, peek_last);
  assign form_eop      = flit_ends(form_size, peek_last);
  assign form_head     = !in_pkt;
  assign out_free      = !fl_valid || fl_ready;
  assign credit_enough = credit_cnt >= CNT_W'(form_size);
  assign form_fire     = (form_size != 2'd0) && credit_enough && out_free;

  nitx_credit_ctrl #(
    .REMOTE_DEPTH (REMOTE_DEPTH),
    .CRED_W       (CRED_W),
    .CNT_W        (CNT_W)
  ) u_credit (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (form_fire),
    .take_n     (form_size),
    .take_head  (form_fire && form_head),
    .rx_valid   (rx_hdr_valid),
    .rx_credit  (rx_hdr_credit),
    .consume    (rx_consume),
    .credit_cnt (credit_cnt),
    .ret_credit (ret_credit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_pkt    <= 1'b0;
      fl_valid  <= 1'b0;
      fl_head   <= 1'b0;
      fl_route  <= '0;
      fl_qid    <= '0;
      fl_credit <= '0;
      fl_size   <= '0;
      fl_eop    <= 1'b0;
      fl_data   <= '0;
    end else if (form_fire) begin
      in_pkt    <= !form_eop;
      fl_valid  <= 1'b1;
      fl_head   <= form_head;
      fl_route  <= form_head ? cfg_route : '0;
      fl_qid    <= form_head ? cfg_qid : '0;
      fl_credit <= form_head ? ret_credit : '0;
      fl_size   <= form_size;
      fl_eop    <= form_eop;
      fl_data   <= form_data;
    end else if (fl_ready) begin
      fl_valid  <= 1'b0;
    end
  end

endmodule

// File: rtl/nitx_packetizer_chk.sv
`timescale 1ns/1ps
module nitx_packetizer_chk #(
  parameter int DATA_W       = 8,
  parameter int QDEPTH       = 8,
  parameter int REMOTE_DEPTH = 6,
  localparam int FLIT_W      = 3 * DATA_W,
  localparam int QCNT_W      = $clog2(QDEPTH) + 1,
  localparam int CNT_W       = $clog2(REMOTE_DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fl_valid,
  input logic              fl_ready,
  input logic              fl_head,
  input logic [1:0]        fl_size,
  input logic              fl_eop,
  input logic [FLIT_W-1:0] fl_data,
  input logic              form_fire,
  input logic [1:0]        form_size,
  input logic [CNT_W-1:0]  credit_cnt,
  input logic              rx_hdr_valid,
  input logic [QCNT_W-1:0] q_count
);

  // R9
  hold_flit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_valid && !fl_ready |=> fl_valid && $stable(fl_data) && $stable(fl_size)
                              && $stable(fl_eop) && $stable(fl_head));

  // R3
  size_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_valid |-> fl_size != 2'd0);

  // R4
  short_is_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_valid && fl_size != 2'd3 |-> fl_eop);

  // R5
  head_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_valid && fl_ready && fl_eop |=> !fl_valid || fl_head);

  // R5
  body_mid_packet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_valid && fl_ready && !fl_eop |=> !fl_valid || !fl_head);

  // R6
  credit_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    form_fire |-> credit_cnt >= CNT_W'(form_size));

  // R6
  credit_spend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    form_fire && !rx_hdr_valid |=> credit_cnt == $past(credit_cnt) - CNT_W'($past(form_size)));

  // R1
  credit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    credit_cnt <= CNT_W'(REMOTE_DEPTH));

  // R10
  queue_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= QCNT_W'(QDEPTH));

endmodule

bind nitx_packetizer nitx_packetizer_chk #(
  .DATA_W       (DATA_W),
  .QDEPTH       (QDEPTH),
  .REMOTE_DEPTH (REMOTE_DEPTH)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .fl_valid     (fl_valid),
  .fl_ready     (fl_ready),
  .fl_head      (fl_head),
  .fl_size      (fl_size),
  .fl_eop       (fl_eop),
  .fl_data      (fl_data),
  .form_fire    (form_fire),
  .form_size    (form_size),
  .credit_cnt   (credit_cnt),
  .rx_hdr_valid (rx_hdr_valid),
  .q_count      (q_count)
);

// File: tb/tb_nitx_packetizer.sv
`timescale 1ns/1ps
module tb_nitx_packetizer;

  localparam int DW = 8;
  localparam int PW = 12;
  localparam int QW = 3;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          msg_valid = 1'b0;
  logic          msg_ready;
  logic [DW-1:0] msg_word = '0;
  logic          msg_last = 1'b0;
  logic [PW-1:0] cfg_route = 12'hA5C;
  logic [QW-1:0] cfg_qid = 3'd5;
  logic          rx_hdr_valid = 1'b0;
  logic [CW-1:0] rx_hdr_credit = '0;
  logic          rx_consume = 1'b0;
  logic          fl_valid;
  logic          fl_ready = 1'b0;
  logic          fl_head;
  logic [PW-1:0] fl_route;
  logic [QW-1:0] fl_qid;
  logic [CW-1:0] fl_credit;
  logic [1:0]    fl_size;
  logic          fl_eop;
  logic [3*DW-1:0] fl_data;

  always #2.5 clk = ~clk;

  nitx_packetizer dut (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_word(msg_word), .msg_last(msg_last), .cfg_route(cfg_route), .cfg_qid(cfg_qid),
    .rx_hdr_valid(rx_hdr_valid), .rx_hdr_credit(rx_hdr_credit), .rx_consume(rx_consume),
    .fl_valid(fl_valid), .fl_ready(fl_ready), .fl_head(fl_head), .fl_route(fl_route),
    .fl_qid(fl_qid), .fl_credit(fl_credit), .fl_size(fl_size), .fl_eop(fl_eop),
    .fl_data(fl_data)
  );

  int n_tests = 0;
  int n_fail = 0;
  int msg_len [64];
  int exp_hc [64];
  int pushed_msgs = 0;
  int pushed_words = 0;
  int acc_flits = 0;
  int acc_words = 0;
  int mon_msg = 0;
  int mon_pos = 0;
  int pending = 0;
  bit ret_en = 1'b0;
  int ready_mode = 0;
  int cyc = 0;
  bit held = 1'b0;
  logic [3*DW-1:0] snap_data;
  logic [1:0]      snap_size;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  // Monitor: sample between clock edges, compare against arithmetic model.
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (held)
        chk(fl_valid && fl_data == snap_data && fl_size == snap_size,
            "R9", "held flit changed", int'(fl_data), int'(snap_data));
      held = fl_valid && !fl_ready;
      snap_data = fl_data;
      snap_size = fl_size;
      if (fl_valid && fl_ready) begin
        int rem, esz;
        rem = msg_len[mon_msg] - mon_pos;
        esz = (rem > 3) ? 3 : rem;
        chk(int'(fl_size) == esz, "R3", "flit size", int'(fl_size), esz);
        chk(fl_eop == (rem == esz), "R4", "end flag", int'(fl_eop), int'(rem == esz));
        chk(fl_head == (mon_pos == 0), "R5", "head flag", int'(fl_head), int'(mon_pos == 0));
        if (mon_pos == 0) begin
          chk(fl_route == cfg_route && fl_qid == cfg_qid, "R5", "route/qid",
              int'(fl_route), int'(cfg_route));
          chk(int'(fl_credit) == exp_hc[mon_msg], "R8", "returned credit",
              int'(fl_credit), exp_hc[mon_msg]);
        end else begin
          chk(fl_route == '0 && fl_qid == '0 && fl_credit == '0, "R5",
              "body header fields", int'(fl_route), 0);
        end
        for (int k = 0; k < 3; k++) begin
          if (k < esz)
            chk(fl_data[k*DW +: DW] == DW'(acc_words + k), "R2", "lane word",
                int'(fl_data[k*DW +: DW]), (acc_words + k) % 256);
          else
            chk(fl_data[k*DW +: DW] == '0, "R2", "unused lane",
                int'(fl_data[k*DW +: DW]), 0);
        end
        acc_words += esz;
        mon_pos += esz;
        pending += esz;
        acc_flits++;
        if (mon_pos == msg_len[mon_msg]) begin
          mon_msg++;
          mon_pos = 0;
        end
      end
    end
  end

  // Remote end: ready pattern and credit return for accepted words.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      case (ready_mode)
        1:       fl_ready = (cyc % 3) != 0;
        2:       fl_ready = (cyc % 4) < 2;
        default: fl_ready = 1'b1;
      endcase
      if (ret_en && pending > 0) begin
        int g;
        g = (pending > 3) ? 3 : pending;
        rx_hdr_valid = 1'b1;
        rx_hdr_credit = CW'(g);
        pending -= g;
      end else begin
        rx_hdr_valid = 1'b0;
        rx_hdr_credit = '0;
      end
    end
  end

  task automatic send_msg(input int len, input int hc);
    msg_len[pushed_msgs] = len;
    exp_hc[pushed_msgs] = hc;
    pushed_msgs++;
    for (int i = 0; i < len; i++) begin
      bit acc;
      msg_valid = 1'b1;
      msg_word = DW'(pushed_words);
      msg_last = (i == len - 1);
      do begin
        @(negedge clk);
        acc = msg_ready;
        @(posedge clk);
        #1;
      end while (!acc);
      pushed_words++;
    end
    msg_valid = 1'b0;
    msg_last = 1'b0;
  endtask

  task automatic drain(input int target);
    while (acc_words < target) @(negedge clk);
    @(posedge clk);
    #1;
  endtask

  task automatic consume_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      rx_consume = 1'b1;
      @(posedge clk);
      #1;
    end
    rx_consume = 1'b0;
  endtask

  initial begin
    int target;
    repeat (3) @(negedge clk);
    chk(fl_valid == 1'b0, "R1", "valid in reset", int'(fl_valid), 0);
    chk(msg_ready == 1'b1, "R1", "ready in reset", int'(msg_ready), 1);
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(fl_valid == 1'b0, "R1", "valid after reset", int'(fl_valid), 0);
    @(posedge clk);
    #1;

    // Credit exhaustion: 6 credits cover 3+1, then a 3-word flit must wait.
    fork
      begin
        send_msg(4, 0);
        send_msg(12, 0);
      end
    join_none
    repeat (40) @(posedge clk);
    @(negedge clk);
    chk(acc_words == 4, "R1", "words sent on initial credit", acc_words, 4);
    chk(acc_flits == 2, "R6", "flits before stall", acc_flits, 2);
    chk(fl_valid == 1'b0, "R6", "no flit without credit", int'(fl_valid), 0);
    chk(msg_ready == 1'b0, "R10", "queue full", int'(msg_ready), 0);
    @(posedge clk);
    #1;
    ret_en = 1'b1;
    drain(16);
    chk(acc_words == 16, "R7", "resume after credit return", acc_words, 16);

    // Returned-credit field: count, clear, saturation.
    consume_pulses(5);
    send_msg(2, 5);
    send_msg(2, 0);
    drain(20);
    consume_pulses(20);
    send_msg(1, 15);
    drain(21);

    // Sweep of message lengths under three ready patterns.
    target = 21;
    for (int m = 0; m < 3; m++) begin
      ready_mode = m;
      cfg_route = PW'(12'h3C1 + m * 12'h111);
      cfg_qid = QW'(m + 1);
      for (int len = 1; len <= 9; len++) begin
        send_msg(len, 0);
        target += len;
      end
      drain(target);
    end
    chk(acc_words == pushed_words, "R2", "all words delivered", acc_words, pushed_words);
    chk(mon_msg == pushed_msgs, "R4", "packets closed", mon_msg, pushed_msgs);
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d words", acc_words, pushed_words);
    summary();
    $finish;
  end

endmodule